// File: doc/BRIEF.md
# Per-Thread Address Monitor Bank

This block keeps one address-watch entry for every hardware thread of a multithreaded core. A thread arms its entry with an address. It then issues a wait request that carries the already-translated physical address. The block replies, one cycle later, whether the thread should go to sleep. While entries wait, the block compares every snooped invalidation and every local store against them. A store is never compared with the entry of the thread that issued it.

When any entry hits, the block emits one core-wide wakeup pulse. It raises an activate bit for each thread that is marked suspended. It also records a pending wakeup in every entry, so the next wait request from any thread returns at once instead of sleeping. Thread IDs outside the configured thread count are rejected with an error pulse.

The wait-request channel uses valid/ready. It is held off for one cycle when an arm request targets the same thread in the same cycle. The requester must then keep valid, ID and address stable until ready is seen high. Arm, snoop and store inputs are always accepted. The response (`mwait_rsp_valid_o`) is a single-cycle pulse with no ready of its own, so the receiver must take it in the cycle it appears.

Top module: `thread_monitor_bank`

## Requirements
- R1: After reset every entry is unarmed, not waiting, has a clear pending-wakeup flag and a zero stored line, and all outputs are zero. A first wait request to any thread therefore answers sleep.
- R2: An arm, or an accepted wait request, whose thread ID is not below N_THREADS causes `err_o` to be 1 in the next cycle. It produces no response and changes no entry.
- R3: An arm request for thread t sets bit t of `armed_o`, stores the given address in slice t of `watch_addr_o` (bits t*ADDR_W and up), and resets that entry's stored line to zero.
- R4: An accepted wait request for thread t, with the pending-wakeup flag clear, stores the physical address with its low log2(LINE_BYTES) bits zeroed and sets bit t of `waiting_o`. In the next cycle `mwait_rsp_valid_o`=1 and `mwait_rsp_sleep_o`=1.
- R5: An accepted wait request for thread t, with the pending-wakeup flag set, answers `mwait_rsp_sleep_o`=0 in the next cycle. It clears only that thread's pending-wakeup flag and leaves the armed bit, waiting bit and stored line unchanged.
- R6: An entry hits only when it is both armed and waiting, and the line address of the snoop or store (low log2(LINE_BYTES) bits ignored) equals its stored line. A hit clears that entry's armed and waiting bits.
- R7: A snoop is compared with every entry. A store from thread s is compared with every entry except entry s. A store whose ID is not below N_THREADS is compared with all entries.
- R8: If any entry hits in a cycle, then in the next cycle `wakeup_o`=1 and `activate_o` equals the `suspended_i` value from the hit cycle. The pending-wakeup flag of every entry is also set. Otherwise both outputs are 0 in the next cycle.
- R9: A wait request accepted in the same cycle as a hit sees the pending wakeup. It answers no sleep and leaves that thread's flag clear.
- R10: `mwait_ready_o` is 0 exactly when `arm_valid_i` and `mwait_valid_i` are both 1 with equal thread IDs. A wait request that is not accepted has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_valid_i | input | 1 | Arm request |
| arm_tid_i | input | TID_W | Thread of the arm request |
| arm_addr_i | input | ADDR_W | Address to watch |
| mwait_valid_i | input | 1 | Wait request valid |
| mwait_ready_o | output | 1 | Wait request accepted |
| mwait_tid_i | input | TID_W | Thread of the wait request |
| mwait_paddr_i | input | ADDR_W | Translated physical address |
| mwait_rsp_valid_o | output | 1 | Wait response pulse |
| mwait_rsp_sleep_o | output | 1 | 1 = thread should sleep |
| snoop_valid_i | input | 1 | Snooped invalidation valid |
| snoop_addr_i | input | ADDR_W | Snooped physical address |
| store_valid_i | input | 1 | Local store valid |
| store_tid_i | input | TID_W | Thread that issued the store |
| store_addr_i | input | ADDR_W | Store physical address |
| suspended_i | input | N_THREADS | Threads currently suspended |
| wakeup_o | output | 1 | Core-wide wakeup pulse |
| activate_o | output | N_THREADS | Threads to activate |
| err_o | output | 1 | Illegal thread ID seen |
| armed_o | output | N_THREADS | Armed bit of each entry |
| waiting_o | output | N_THREADS | Waiting bit of each entry |
| watch_addr_o | output | N_THREADS*ADDR_W | Armed address of each entry |

## Verification
The store path is swept over every pairing of issuing thread and target thread. Self-stores must stay silent while cross-thread stores wake the whole core, which separates the sender exclusion from plain matching. Snoops are tried three ways: at a different byte of a watched line, which must hit; at the neighbouring line, which must not; and against entries that are armed-only or waiting-only, which exposes a hit test missing either gate. Wait requests are issued both with and without a pending wakeup, and in the same cycle as a hit. Illegal IDs and same-thread arm/wait collisions are applied to show that error, back-pressure and state preservation are kept apart.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
  localparam int unsigned TMB_DEF_THREADS = 4;
  localparam int unsigned TMB_DEF_TID_W   = 3;
  localparam int unsigned TMB_DEF_ADDR_W  = 32;
  localparam int unsigned TMB_DEF_LINE    = 64;

  // Number of byte-offset bits inside one line (at least one line byte)
  function automatic int unsigned tmb_off_bits(input int unsigned line_bytes);
    return (line_bytes > 1) ? $clog2(line_bytes) : 0;
  endfunction
endpackage

// File: rtl/tmb_tid_decode.sv
module tmb_tid_decode #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned TID_W     = 3
) (
  input  logic                 valid_i,
  input  logic [TID_W-1:0]     tid_i,
  output logic [N_THREADS-1:0] sel_o,
  output logic                 bad_o
);
  localparam logic [TID_W:0] LIMIT = (TID_W+1)'(N_THREADS);

  for (genvar g = 0; g < N_THREADS; g++) begin : g_sel
    assign sel_o[g] = valid_i && ({1'b0, tid_i} == (TID_W+1)'(g));
  end

  assign bad_o = valid_i && ({1'b0, tid_i} >= LIMIT);
endmodule

// File: rtl/tmb_entry.sv
module tmb_entry #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_chk_i,
  input  logic [ADDR_W-1:0] snoop_line_i,
  input  logic              store_chk_i,
  input  logic [ADDR_W-1:0] store_line_i,
  input  logic              any_hit_i,
  input  logic              arm_sel_i,
  input  logic [ADDR_W-1:0] arm_addr_i,
  input  logic              mw_sel_i,
  input  logic [ADDR_W-1:0] mw_line_i,
  output logic              hit_o,
  output logic              sleep_o,
  output logic              armed_o,
  output logic              waiting_o,
  output logic [ADDR_W-1:0] watch_addr_o
);
  logic              armed_q, waiting_q, wake_q;
  logic              armed_d, waiting_d, wake_d;
  logic [ADDR_W-1:0] line_q, line_d, addr_q, addr_d;
  logic              wake_eff;

  assign hit_o = armed_q && waiting_q &&
                 ((snoop_chk_i && (line_q == snoop_line_i)) ||
                  (store_chk_i && (line_q == store_line_i)));

  // a hit in this very cycle counts as an already pending wakeup
  assign wake_eff = wake_q || any_hit_i;
  assign sleep_o  = !wake_eff;

  always_comb begin
    armed_d   = armed_q;
    waiting_d = waiting_q;
    wake_d    = wake_q;
    line_d    = line_q;
    addr_d    = addr_q;
    if (hit_o) begin
      armed_d   = 1'b0;
      waiting_d = 1'b0;
    end
    if (any_hit_i) wake_d = 1'b1;
    if (arm_sel_i) begin
      armed_d = 1'b1;
      addr_d  = arm_addr_i;
      line_d  = '0;
    end
    if (mw_sel_i) begin
      if (wake_eff) begin
        wake_d = 1'b0;
      end else begin
        line_d    = mw_line_i;
        waiting_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      waiting_q <= 1'b0;
      wake_q    <= 1'b0;
      line_q    <= '0;
      addr_q    <= '0;
    end else begin
      armed_q   <= armed_d;
      waiting_q <= waiting_d;
      wake_q    <= wake_d;
      line_q    <= line_d;
      addr_q    <= addr_d;
    end
  end

  assign armed_o      = armed_q;
  assign waiting_o    = waiting_q;
  assign watch_addr_o = addr_q;
endmodule

// File: rtl/thread_monitor_bank.sv
module thread_monitor_bank
  import tmb_pkg::*;
#(
  parameter int unsigned N_THREADS  = TMB_DEF_THREADS,
  parameter int unsigned TID_W      = TMB_DEF_TID_W,
  parameter int unsigned ADDR_W     = TMB_DEF_ADDR_W,
  parameter int unsigned LINE_BYTES = TMB_DEF_LINE
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        arm_valid_i,
  input  logic [TID_W-1:0]            arm_tid_i,
  input  logic [ADDR_W-1:0]           arm_addr_i,
  input  logic                        mwait_valid_i,
  output logic                        mwait_ready_o,
  input  logic [TID_W-1:0]            mwait_tid_i,
  input  logic [ADDR_W-1:0]           mwait_paddr_i,
  output logic                        mwait_rsp_valid_o,
  output logic                        mwait_rsp_sleep_o,
  input  logic                        snoop_valid_i,
  input  logic [ADDR_W-1:0]           snoop_addr_i,
  input  logic                        store_valid_i,
  input  logic [TID_W-1:0]            store_tid_i,
  input  logic [ADDR_W-1:0]           store_addr_i,
  input  logic [N_THREADS-1:0]        suspended_i,
  output logic                        wakeup_o,
  output logic [N_THREADS-1:0]        activate_o,
  output logic                        err_o,
  output logic [N_THREADS-1:0]        armed_o,
  output logic [N_THREADS-1:0]        waiting_o,
  output logic [N_THREADS*ADDR_W-1:0] watch_addr_o
);
  localparam int unsigned OFF_W = tmb_off_bits(LINE_BYTES);
  localparam logic [ADDR_W-1:0] LINE_MASK = ~ADDR_W'((1 << OFF_W) - 1);

  logic [N_THREADS-1:0] arm_sel, mw_sel, hit_vec, sleep_vec, store_chk;
  logic                 arm_bad, mw_bad, mw_acc, any_hit;
  logic [ADDR_W-1:0]    snoop_line, store_line, mw_line;

  assign mwait_ready_o = !(arm_valid_i && mwait_valid_i && (arm_tid_i == mwait_tid_i));
  assign mw_acc        = mwait_valid_i && mwait_ready_o;

  assign snoop_line = snoop_addr_i  & LINE_MASK;
  assign store_line = store_addr_i  & LINE_MASK;
  assign mw_line    = mwait_paddr_i & LINE_MASK;

  tmb_tid_decode #(.N_THREADS(N_THREADS), .TID_W(TID_W)) arm_dec_i (
    .valid_i(arm_valid_i), .tid_i(arm_tid_i), .sel_o(arm_sel), .bad_o(arm_bad)
  );

  tmb_tid_decode #(.N_THREADS(N_THREADS), .TID_W(TID_W)) mw_dec_i (
    .valid_i(mw_acc), .tid_i(mwait_tid_i), .sel_o(mw_sel), .bad_o(mw_bad)
  );

  for (genvar t = 0; t < N_THREADS; t++) begin : g_mon
    // the issuing thread never observes its own store
    assign store_chk[t] = store_valid_i && ({1'b0, store_tid_i} != (TID_W+1)'(t));

    tmb_entry #(.ADDR_W(ADDR_W)) entry_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .snoop_chk_i  (snoop_valid_i),
      .snoop_line_i (snoop_line),
      .store_chk_i  (store_chk[t]),
      .store_line_i (store_line),
      .any_hit_i    (any_hit),
      .arm_sel_i    (arm_sel[t]),
      .arm_addr_i   (arm_addr_i),
      .mw_sel_i     (mw_sel[t]),
      .mw_line_i    (mw_line),
      .hit_o        (hit_vec[t]),
      .sleep_o      (sleep_vec[t]),
      .armed_o      (armed_o[t]),
      .waiting_o    (waiting_o[t]),
      .watch_addr_o (watch_addr_o[t*ADDR_W +: ADDR_W])
    );
  end

  assign any_hit = |hit_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mwait_rsp_valid_o <= 1'b0;
      mwait_rsp_sleep_o <= 1'b0;
      wakeup_o          <= 1'b0;
      activate_o        <= '0;
      err_o             <= 1'b0;
    end else begin
      mwait_rsp_valid_o <= |mw_sel;
      mwait_rsp_sleep_o <= |(mw_sel & sleep_vec);
      wakeup_o          <= any_hit;
      activate_o        <= any_hit ? suspended_i : '0;
      err_o             <= arm_bad || mw_bad;
    end
  end
endmodule

// File: rtl/tmb_checker.sv
module tmb_checker #(
  parameter int unsigned N_THREADS = 4,
  parameter int unsigned TID_W     = 3,
  parameter int unsigned ADDR_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        arm_valid_i,
  input logic [TID_W-1:0]            arm_tid_i,
  input logic                        mwait_valid_i,
  input logic                        mwait_ready_o,
  input logic [TID_W-1:0]            mwait_tid_i,
  input logic                        mwait_rsp_valid_o,
  input logic                        mwait_rsp_sleep_o,
  input logic                        snoop_valid_i,
  input logic                        store_valid_i,
  input logic [N_THREADS-1:0]        suspended_i,
  input logic                        wakeup_o,
  input logic [N_THREADS-1:0]        activate_o,
  input logic [N_THREADS-1:0]        armed_o,
  input logic [N_THREADS-1:0]        waiting_o,
  input logic [N_THREADS*ADDR_W-1:0] watch_addr_o
);
  p_bad_arm_keeps_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_valid_i && (int'(arm_tid_i) >= N_THREADS) && !mwait_valid_i &&
     !snoop_valid_i && !store_valid_i)
    |=> ($stable(armed_o) && $stable(waiting_o) && $stable(watch_addr_o) && !mwait_rsp_valid_o));

  p_rsp_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mwait_valid_i && mwait_ready_o && (int'(mwait_tid_i) < N_THREADS)) |=> mwait_rsp_valid_o);

  p_sleep_leaves_waiter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mwait_rsp_valid_o && mwait_rsp_sleep_o) |-> (waiting_o != '0));

  p_activate_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((activate_o & ~$past(suspended_i)) == '0) && ((activate_o == '0) || wakeup_o));

  p_hit_beats_sleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mwait_rsp_valid_o && mwait_rsp_sleep_o) |-> !wakeup_o);
endmodule

bind thread_monitor_bank tmb_checker #(
  .N_THREADS(N_THREADS), .TID_W(TID_W), .ADDR_W(ADDR_W)
) tmb_checker_i (.*);

// File: tb/thread_monitor_bank_tb_top.sv
`timescale 1ns/1ps
module thread_monitor_bank_tb_top;
  localparam int NT = 4;
  localparam int TW = 3;
  localparam int AW = 32;
  localparam logic [AW-1:0] MASK = ~32'h3F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_valid_i = 0, mwait_valid_i = 0, snoop_valid_i = 0, store_valid_i = 0;
  logic [TW-1:0] arm_tid_i = '0, mwait_tid_i = '0, store_tid_i = '0;
  logic [AW-1:0] arm_addr_i = '0, mwait_paddr_i = '0, snoop_addr_i = '0, store_addr_i = '0;
  logic [NT-1:0] suspended_i = '0;
  logic mwait_ready_o, mwait_rsp_valid_o, mwait_rsp_sleep_o, wakeup_o, err_o;
  logic [NT-1:0] activate_o, armed_o, waiting_o;
  logic [NT*AW-1:0] watch_addr_o;

  int checks = 0, fails = 0, cyc = 0;
  bit m_armed[NT], m_wait[NT], m_wake[NT];
  logic [AW-1:0] m_line[NT], m_addr[NT];

  always #2 clk = ~clk;

  thread_monitor_bank #(.N_THREADS(NT), .TID_W(TW), .ADDR_W(AW), .LINE_BYTES(64)) dut_i (.*);

  task automatic chk(input string tag, input string what, input logic [NT*AW-1:0] act,
                     input logic [NT*AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input string tag, input bit av, input int at, input logic [AW-1:0] aa,
                       input bit mv, input int mt, input logic [AW-1:0] ma,
                       input bit sv, input logic [AW-1:0] sa,
                       input bit tv, input int tt, input logic [AW-1:0] ta,
                       input logic [NT-1:0] susp);
    bit rdy, any, e_rv, e_sl, e_err;
    bit hit[NT];
    bit n_armed[NT], n_wait[NT], n_wake[NT];
    logic [AW-1:0] n_line[NT], n_addr[NT];
    logic [NT-1:0] e_act, e_armed, e_wait;
    logic [NT*AW-1:0] e_addr;
    arm_valid_i = av; arm_tid_i = TW'(at); arm_addr_i = aa;
    mwait_valid_i = mv; mwait_tid_i = TW'(mt); mwait_paddr_i = ma;
    snoop_valid_i = sv; snoop_addr_i = sa;
    store_valid_i = tv; store_tid_i = TW'(tt); store_addr_i = ta;
    suspended_i = susp;
    rdy = !(av && mv && at == mt);
    #1;
    chk(tag, "ready R10", {127'b0, mwait_ready_o}, {127'b0, rdy});
    any = 0;
    for (int t = 0; t < NT; t++) begin
      hit[t] = m_armed[t] && m_wait[t] &&
               ((sv && m_line[t] == (sa & MASK)) || (tv && tt != t && m_line[t] == (ta & MASK)));
      any |= hit[t];
      n_armed[t] = m_armed[t]; n_wait[t] = m_wait[t]; n_wake[t] = m_wake[t];
      n_line[t] = m_line[t]; n_addr[t] = m_addr[t];
      if (hit[t]) begin n_armed[t] = 0; n_wait[t] = 0; end
      if (any_hit_dummy(0)) ;
    end
    for (int t = 0; t < NT; t++) if (any) n_wake[t] = 1;
    if (av && at < NT) begin n_armed[at] = 1; n_addr[at] = aa; n_line[at] = '0; end
    e_rv = 0; e_sl = 0;
    if (mv && rdy && mt < NT) begin
      e_rv = 1;
      if (m_wake[mt] || any) n_wake[mt] = 0;
      else begin n_line[mt] = ma & MASK; n_wait[mt] = 1; e_sl = 1; end
    end
    e_err = (av && at >= NT) || (mv && rdy && mt >= NT);
    e_act = any ? susp : '0;
    for (int t = 0; t < NT; t++) begin
      m_armed[t] = n_armed[t]; m_wait[t] = n_wait[t]; m_wake[t] = n_wake[t];
      m_line[t] = n_line[t]; m_addr[t] = n_addr[t];
      e_armed[t] = n_armed[t]; e_wait[t] = n_wait[t];
      e_addr[t*AW +: AW] = n_addr[t];
    end
    @(negedge clk);
    chk(tag, "rsp_valid", {127'b0, mwait_rsp_valid_o}, {127'b0, e_rv});
    if (e_rv) chk(tag, "rsp_sleep", {127'b0, mwait_rsp_sleep_o}, {127'b0, e_sl});
    chk(tag, "wakeup", {127'b0, wakeup_o}, {127'b0, any});
    chk(tag, "activate", {124'b0, activate_o}, {124'b0, e_act});
    chk(tag, "err", {127'b0, err_o}, {127'b0, e_err});
    chk(tag, "armed", {124'b0, armed_o}, {124'b0, e_armed});
    chk(tag, "waiting", {124'b0, waiting_o}, {124'b0, e_wait});
    chk(tag, "watch_addr", watch_addr_o, e_addr);
  endtask

  function automatic bit any_hit_dummy(input int x);
    return x != 0;
  endfunction

  task automatic arm(input string tag, input int t, input logic [AW-1:0] a);
    drive(tag, 1, t, a, 0, 0, 0, 0, 0, 0, 0, 0, '0);
  endtask
  task automatic mwait(input string tag, input int t, input logic [AW-1:0] a);
    drive(tag, 0, 0, 0, 1, t, a, 0, 0, 0, 0, 0, '0);
  endtask
  task automatic snoop(input string tag, input logic [AW-1:0] a, input logic [NT-1:0] s);
    drive(tag, 0, 0, 0, 0, 0, 0, 1, a, 0, 0, 0, s);
  endtask
  task automatic store(input string tag, input int t, input logic [AW-1:0] a, input logic [NT-1:0] s);
    drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 1, t, a, s);
  endtask
  task automatic drain_wake();
    for (int t = 0; t < NT; t++) if (m_wake[t]) mwait("R5", t, 32'h0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin
      m_armed[t] = 0; m_wait[t] = 0; m_wake[t] = 0; m_line[t] = '0; m_addr[t] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state at the ports
    chk("R1", "armed", {124'b0, armed_o}, '0);
    chk("R1", "waiting", {124'b0, waiting_o}, '0);
    chk("R1", "watch_addr", watch_addr_o, '0);
    chk("R1", "outputs", {123'b0, wakeup_o, activate_o}, '0);
    chk("R1", "rsp", {126'b0, mwait_rsp_valid_o, err_o}, '0);
    // R1/R4: fresh wait requests sleep
    for (int t = 0; t < NT; t++) mwait("R1", t, 32'h1000 + 32'(t) * 32'h40 + 32'h7);
    // R6: waiting but not armed never hits
    snoop("R6", 32'h1000, 4'hF);
    // R3: arm clears line to zero; snoop line 0 now hits armed+waiting entry 0
    arm("R3", 0, 32'hABCD_0123);
    snoop("R6", 32'h0000_0021, 4'b0101);
    drain_wake();
    // R7: exhaustive store sender/target sweep
    for (int s = 0; s < NT; s++) begin
      for (int t = 0; t < NT; t++) begin
        logic [AW-1:0] base;
        base = 32'h0002_0000 + 32'(s * 256 + t * 64);
        arm("R3", t, base + 32'h11);
        mwait("R4", t, base + 32'h3);
        store("R7", s, base + 32'h3C, 4'(s + t));
        if (s == t) store("R7", (t + 1) % NT, base, 4'b1001);
        drain_wake();
      end
    end
    // R6: neighbouring line misses, other byte of same line hits
    for (int t = 0; t < NT; t++) begin
      arm("R3", t, 32'h5000 + 32'(t));
      mwait("R4", t, 32'h0008_0000 + 32'(t) * 32'h80);
    end
    snoop("R6", 32'h0008_0040, 4'hF);
    snoop("R8", 32'h0008_013F, 4'b1010);
    mwait("R5", 2, 32'h0);
    drain_wake();
    // store with out-of-range id checks every entry
    store("R7", 6, 32'h0008_0000, 4'b0110);
    drain_wake();
    // R9: wait request in the hit cycle answers no sleep
    arm("R3", 1, 32'h700);
    mwait("R4", 1, 32'h0009_0000);
    drive("R9", 0, 0, 0, 1, 3, 32'h0009_1000, 1, 32'h0009_0010, 0, 0, 0, 4'b1000);
    drain_wake();
    // R2: illegal ids
    arm("R3", 2, 32'h9999);
    for (int b = NT; b < 8; b++) begin
      arm("R2", b, 32'hDEAD_0000);
      mwait("R2", b, 32'hBEEF_0000);
    end
    drive("R2", 1, 5, 32'h1, 1, 7, 32'h2, 0, 0, 0, 0, 0, '0);
    // R10: same-thread collision holds off the wait request
    drive("R10", 1, 2, 32'h4444, 1, 2, 32'h000A_0000, 0, 0, 0, 0, 0, '0);
    drive("R10", 1, 1, 32'h5555, 1, 2, 32'h000A_0000, 0, 0, 0, 0, 0, '0);
    snoop("R6", 32'h000A_0004, 4'hF);
    drain_wake();
    drive("R1", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule